// File: doc/BRIEF.md
# Block Transfer Burst Engine

This engine copies a run of fixed-size storage blocks between a word-addressed block store and system memory. Software-side logic hands it a direction, a memory buffer address, a first block index and a block count, then pulses `start`. The engine acts as a bus initiator. It breaks every block into fixed-length memory bursts and stages each burst in a small local buffer. It steps both the memory byte address and the storage word address as it goes.

For each burst, the storage side and the memory side are served in turn, never at once. A copy towards memory first fills the buffer from storage and then writes it to memory as one burst. A copy towards storage first reads one burst from memory and then writes the buffer to storage. The request is checked before any traffic starts: the block range must fit the device and the buffer address must be word-aligned. When the run ends, a one-cycle `done` pulse carries a two-bit outcome code. The code separates success from failure and reads from writes.

Top module: `dmab_engine`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `m_req` and `s_en` are 0, and they stay 0 until a start is accepted.
- R2: With `dir_to_disk`=0, storage words starting at word index `first_lba`*BLOCK_WORDS are copied, in order, to memory starting at `buf_addr`, for `blk_cnt` blocks. Memory words just outside that range are not written.
- R3: With `dir_to_disk`=1, memory words starting at `buf_addr` are copied to storage starting at word `first_lba`*BLOCK_WORDS, for `blk_cnt` blocks. Storage words just outside that range are not written.
- R4: Memory traffic consists of bursts of BURST_BYTES/word-size beats. `m_addr` carries the burst base address, which is first `buf_addr` and then grows by BURST_BYTES per burst. `m_addr` and `m_last` hold while a beat is stalled, and `m_last` is 1 exactly on the final beat. `m_wr` is 1 only when writing memory.
- R5: Storage accesses use consecutive word indices from `first_lba`*BLOCK_WORDS. A transfer makes exactly `blk_cnt`*BLOCK_WORDS storage accesses and the same number of memory beats.
- R6: At the end of a run, `done` is high for exactly one cycle, with `outcome` = 0 for read success, 1 for write success, 2 for read error and 3 for write error. `busy` is low on the following cycle.
- R7: If `first_lba`+`blk_cnt` exceeds DEV_BLOCKS, the error code for the direction is returned with no memory or storage traffic. A range ending exactly at DEV_BLOCKS is accepted.
- R8: A `buf_addr` whose low log2(word bytes) bits are not zero gives the error code for the direction, with no traffic.
- R9: A beat answered with `m_err`=1 together with `m_ack` ends the run. No further memory or storage access follows, and the outcome is the error code for the direction.
- R10: A start with `blk_cnt`=0 and an otherwise valid request gives the success code for the direction, with no traffic.
- R11: A start pulse while `busy` is 1 is ignored. The running transfer's data, addresses and outcome are unchanged, and no second run follows.
- R12: `m_req` and `s_en` are never both 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| start | input | 1 | Start pulse, taken only when idle |
| dir_to_disk | input | 1 | 0: storage to memory, 1: memory to storage |
| buf_addr | input | ADDR_W | Memory buffer byte address |
| first_lba | input | LBA_W | Index of the first block |
| blk_cnt | input | CNT_W | Number of blocks |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| outcome | output | 2 | Result code, valid with done |
| m_req | output | 1 | Memory burst beat request |
| m_wr | output | 1 | 1: memory write, 0: memory read |
| m_addr | output | ADDR_W | Burst base byte address |
| m_last | output | 1 | Final beat of the burst |
| m_wdata | output | DATA_W | Memory write data |
| m_ack | input | 1 | Beat accepted |
| m_err | input | 1 | Error response for the acknowledged beat |
| m_rdata | input | DATA_W | Memory read data, valid with m_ack |
| s_en | output | 1 | Storage access enable |
| s_we | output | 1 | Storage write enable |
| s_addr | output | SADDR_W | Storage word index |
| s_wdata | output | DATA_W | Storage write data |
| s_rdata | input | DATA_W | Storage read data, one cycle after a read |

## Verification
Transfers are run in both directions, over one and several blocks, with memory acknowledges that arrive every cycle or with stalls at two different rates. Those runs separate a correct beat and address sequence from one that only works without back-pressure. Requests just inside and just outside the device range, a misaligned buffer and a zero count each isolate one early-exit path, and each is tried with the direction that selects the other error code. Injected bus errors, one in each direction at a mid-transfer beat, show that the abort stops all traffic on both sides. A start pulse sent in the middle of a run shows that it is ignored.

// File: rtl/dmab_pkg.sv
package dmab_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DISK = 2'd1,
    ST_MEM  = 2'd2,
    ST_DONE = 2'd3
  } dmab_state_e;

  // outcome code: bit1 = failed, bit0 = towards storage
  typedef enum logic [1:0] {
    OUT_RD_OK  = 2'd0,
    OUT_WR_OK  = 2'd1,
    OUT_RD_ERR = 2'd2,
    OUT_WR_ERR = 2'd3
  } dmab_outcome_e;

  function automatic logic [1:0] outcome_code(input logic to_disk, input logic failed);
    return {failed, to_disk};
  endfunction

endpackage

// File: rtl/dmab_burst_buf.sv
module dmab_burst_buf #(
  parameter int DATA_W = 32,
  parameter int BEATS  = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] word_q [BEATS];

  // staging storage, no reset needed: every word is written before read
  always_ff @(posedge clk) begin
    if (wr_en) begin
      word_q[wr_idx] <= wr_data;
    end
  end

  assign rd_data = word_q[rd_idx];

endmodule

// File: rtl/dmab_addr_gen.sv
module dmab_addr_gen #(
  parameter int ADDR_W      = 32,
  parameter int SADDR_W     = 21,
  parameter int LBA_W       = 16,
  parameter int CNT_W       = 8,
  parameter int LEFT_W      = 11,
  parameter int BURST_BYTES = 16,
  parameter int BLK_SH      = 5,
  parameter int BPB_SH      = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [ADDR_W-1:0]  buf_addr,
  input  logic [LBA_W-1:0]   first_lba,
  input  logic [CNT_W-1:0]   blk_cnt,
  input  logic               step_word,
  input  logic               step_burst,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [SADDR_W-1:0] st_addr,
  output logic               last_burst
);

  logic [ADDR_W-1:0]  mem_q, mem_d;
  logic [SADDR_W-1:0] st_q, st_d;
  logic [LEFT_W-1:0]  left_q, left_d;
  logic               en;

  always_comb begin
    mem_d  = mem_q;
    st_d   = st_q;
    left_d = left_q;
    if (load) begin
      mem_d  = buf_addr;
      st_d   = SADDR_W'(first_lba) << BLK_SH;
      left_d = LEFT_W'(blk_cnt) << BPB_SH;
    end else begin
      if (step_word) begin
        st_d = st_q + SADDR_W'(1);
      end
      if (step_burst) begin
        mem_d  = mem_q + ADDR_W'(BURST_BYTES);
        left_d = left_q - LEFT_W'(1);
      end
    end
  end

  assign en = load | step_word | step_burst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q  <= '0;
      st_q   <= '0;
      left_q <= '0;
    end else if (en) begin
      mem_q  <= mem_d;
      st_q   <= st_d;
      left_q <= left_d;
    end
  end

  assign mem_addr   = mem_q;
  assign st_addr    = st_q;
  assign last_burst = (left_q == LEFT_W'(1));

endmodule

// File: rtl/dmab_engine.sv
module dmab_engine
  import dmab_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int LBA_W       = 16,
  parameter int CNT_W       = 8,
  parameter int BURST_BYTES = 16,
  parameter int BLOCK_BYTES = 128,
  parameter int DEV_BLOCKS  = 64,
  localparam int WORD_BYTES  = DATA_W / 8,
  localparam int WOFF        = $clog2(WORD_BYTES),
  localparam int BEATS       = BURST_BYTES / WORD_BYTES,
  localparam int IDX_W       = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int BLK_SH      = $clog2(BLOCK_BYTES / WORD_BYTES),
  localparam int BPB_SH      = $clog2(BLOCK_BYTES / BURST_BYTES),
  localparam int SADDR_W     = LBA_W + BLK_SH,
  localparam int LEFT_W      = CNT_W + BPB_SH,
  localparam int RNG_W       = ((LBA_W > CNT_W) ? LBA_W : CNT_W) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               dir_to_disk,
  input  logic [ADDR_W-1:0]  buf_addr,
  input  logic [LBA_W-1:0]   first_lba,
  input  logic [CNT_W-1:0]   blk_cnt,
  output logic               busy,
  output logic               done,
  output logic [1:0]         outcome,
  output logic               m_req,
  output logic               m_wr,
  output logic [ADDR_W-1:0]  m_addr,
  output logic               m_last,
  output logic [DATA_W-1:0]  m_wdata,
  input  logic               m_ack,
  input  logic               m_err,
  input  logic [DATA_W-1:0]  m_rdata,
  output logic               s_en,
  output logic               s_we,
  output logic [SADDR_W-1:0] s_addr,
  output logic [DATA_W-1:0]  s_wdata,
  input  logic [DATA_W-1:0]  s_rdata
);

  localparam logic [IDX_W:0]  BEATS_V = (IDX_W + 1)'(BEATS);
  localparam logic [IDX_W:0]  LAST_V  = (IDX_W + 1)'(BEATS - 1);
  localparam logic [RNG_W-1:0] DEV_V  = RNG_W'(DEV_BLOCKS);

  dmab_state_e        state_q, state_d;
  logic [IDX_W:0]     beat_q, beat_d;
  logic               dir_q, dir_d;
  logic [1:0]         out_q, out_d;
  logic               cap_v_q, cap_v_d;
  logic [IDX_W-1:0]   cap_idx_q, cap_idx_d;

  logic               load, step_word, step_burst, last_burst;
  logic               bw_en;
  logic [IDX_W-1:0]   bw_idx;
  logic [DATA_W-1:0]  bw_data, br_data;
  logic               bad_range, bad_align;

  assign bad_range = (RNG_W'(first_lba) + RNG_W'(blk_cnt)) > DEV_V;
  assign bad_align = |buf_addr[WOFF-1:0];

  dmab_addr_gen #(
    .ADDR_W(ADDR_W), .SADDR_W(SADDR_W), .LBA_W(LBA_W), .CNT_W(CNT_W),
    .LEFT_W(LEFT_W), .BURST_BYTES(BURST_BYTES), .BLK_SH(BLK_SH), .BPB_SH(BPB_SH)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load), .buf_addr(buf_addr),
    .first_lba(first_lba), .blk_cnt(blk_cnt), .step_word(step_word),
    .step_burst(step_burst), .mem_addr(m_addr), .st_addr(s_addr),
    .last_burst(last_burst)
  );

  dmab_burst_buf #(.DATA_W(DATA_W), .BEATS(BEATS), .IDX_W(IDX_W)) u_buf (
    .clk(clk), .wr_en(bw_en), .wr_idx(bw_idx), .wr_data(bw_data),
    .rd_idx(beat_q[IDX_W-1:0]), .rd_data(br_data)
  );

  assign m_wdata = br_data;
  assign s_wdata = br_data;
  assign busy    = (state_q != ST_IDLE);
  assign done    = (state_q == ST_DONE);
  assign outcome = out_q;
  assign m_wr    = (state_q == ST_MEM) && !dir_q;
  assign m_last  = (state_q == ST_MEM) && (beat_q == LAST_V);

  always_comb begin
    state_d    = state_q;
    beat_d     = beat_q;
    dir_d      = dir_q;
    out_d      = out_q;
    load       = 1'b0;
    step_word  = 1'b0;
    step_burst = 1'b0;
    bw_en      = 1'b0;
    bw_idx     = beat_q[IDX_W-1:0];
    bw_data    = m_rdata;
    m_req      = 1'b0;
    s_en       = 1'b0;
    s_we       = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          dir_d  = dir_to_disk;
          load   = 1'b1;
          beat_d = '0;
          if (bad_range || bad_align) begin
            out_d   = outcome_code(dir_to_disk, 1'b1);
            state_d = ST_DONE;
          end else if (blk_cnt == '0) begin
            out_d   = outcome_code(dir_to_disk, 1'b0);
            state_d = ST_DONE;
          end else begin
            state_d = dir_to_disk ? ST_MEM : ST_DISK;
          end
        end
      end
      ST_DISK: begin
        if (!dir_q) begin
          // storage read: issue BEATS reads, capture one cycle later
          if (beat_q != BEATS_V) begin
            s_en      = 1'b1;
            step_word = 1'b1;
            beat_d    = beat_q + 1'b1;
          end
          if (cap_v_q) begin
            bw_en   = 1'b1;
            bw_idx  = cap_idx_q;
            bw_data = s_rdata;
            if (cap_idx_q == LAST_V[IDX_W-1:0]) begin
              beat_d  = '0;
              state_d = ST_MEM;
            end
          end
        end else begin
          s_en      = 1'b1;
          s_we      = 1'b1;
          step_word = 1'b1;
          if (beat_q == LAST_V) begin
            beat_d     = '0;
            step_burst = 1'b1;
            if (last_burst) begin
              out_d   = OUT_WR_OK;
              state_d = ST_DONE;
            end else begin
              state_d = ST_MEM;
            end
          end else begin
            beat_d = beat_q + 1'b1;
          end
        end
      end
      ST_MEM: begin
        m_req = 1'b1;
        if (m_ack) begin
          if (m_err) begin
            out_d   = outcome_code(dir_q, 1'b1);
            state_d = ST_DONE;
          end else begin
            bw_en = dir_q;
            if (beat_q == LAST_V) begin
              beat_d = '0;
              if (dir_q) begin
                state_d = ST_DISK;
              end else begin
                step_burst = 1'b1;
                if (last_burst) begin
                  out_d   = OUT_RD_OK;
                  state_d = ST_DONE;
                end else begin
                  state_d = ST_DISK;
                end
              end
            end else begin
              beat_d = beat_q + 1'b1;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign cap_v_d   = s_en && !s_we;
  assign cap_idx_d = beat_q[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      beat_q    <= '0;
      dir_q     <= 1'b0;
      out_q     <= OUT_RD_OK;
      cap_v_q   <= 1'b0;
      cap_idx_q <= '0;
    end else begin
      state_q   <= state_d;
      beat_q    <= beat_d;
      dir_q     <= dir_d;
      out_q     <= out_d;
      cap_v_q   <= cap_v_d;
      cap_idx_q <= cap_idx_d;
    end
  end

  // R12: the two sides are served in turn
  a_r12_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_req && s_en));

  // R6: done is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4: a stalled beat keeps its address and last flag
  a_r4_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_last)));

  // R1: no traffic when idle
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!m_req && !s_en));

  // R9: an error response stops all traffic and ends the run
  a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_ack && m_err) |=> (done && !m_req && !s_en));

endmodule

// File: tb/dmab_engine_test.sv
`timescale 1ns/1ps
module dmab_engine_test;

  localparam int BEATS   = 4;
  localparam int BLKW    = 32;
  localparam int SADDR_W = 21;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start = 1'b0;
  logic               dir_to_disk = 1'b0;
  logic [31:0]        buf_addr = '0;
  logic [15:0]        first_lba = '0;
  logic [7:0]         blk_cnt = '0;
  logic               busy, done, m_req, m_wr, m_last, s_en, s_we;
  logic [1:0]         outcome;
  logic [31:0]        m_addr, m_wdata, s_wdata;
  logic [SADDR_W-1:0] s_addr;
  logic               m_ack = 1'b0, m_err = 1'b0;
  logic [31:0]        m_rdata = '0, s_rdata = '0;

  dmab_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_to_disk(dir_to_disk),
    .buf_addr(buf_addr), .first_lba(first_lba), .blk_cnt(blk_cnt),
    .busy(busy), .done(done), .outcome(outcome),
    .m_req(m_req), .m_wr(m_wr), .m_addr(m_addr), .m_last(m_last),
    .m_wdata(m_wdata), .m_ack(m_ack), .m_err(m_err), .m_rdata(m_rdata),
    .s_en(s_en), .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata),
    .s_rdata(s_rdata)
  );

  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;

  logic [31:0] mem   [4096];
  logic [31:0] store [2048];

  // reference model state
  int          t_dir, t_err_beat, t_stall;
  longint      exp_maddr, exp_saddr;
  int          bib, beats, acc_s, bad_m, bad_s, overlap, cyc;
  bit          pend_v;
  int          pend_a;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural memory and storage models, compared every clock
  always @(negedge clk) begin
    m_ack = 1'b0;
    m_err = 1'b0;
    if (rst_n) begin
      cyc++;
      if (pend_v) s_rdata = store[pend_a];
      pend_v = 1'b0;
      if (m_req && s_en) overlap++;
      if (s_en) begin
        acc_s++;
        if (longint'(s_addr) != exp_saddr) bad_s++;
        exp_saddr++;
        if (s_we) store[s_addr[10:0]] = s_wdata;
        else begin pend_v = 1'b1; pend_a = int'(s_addr[10:0]); end
      end
      if (m_req && (t_stall == 0 || (cyc % t_stall) != 0)) begin
        m_ack = 1'b1;
        beats++;
        if (longint'(m_addr) != exp_maddr || m_last != (bib == BEATS-1)
            || m_wr != (t_dir == 0)) bad_m++;
        if (beats == t_err_beat) m_err = 1'b1;
        else if (m_wr) mem[((m_addr >> 2) + bib) % 4096] = m_wdata;
        else m_rdata = mem[((m_addr >> 2) + bib) % 4096];
        bib++;
        if (bib == BEATS) begin bib = 0; exp_maddr += 16; end
      end
    end
  end

  int got_out;

  task automatic run(input int dir, input int bufa, input int lba, input int cnt,
                     input int errb, input int stall, input bit poke);
    bit seen;
    t_dir = dir; t_err_beat = errb; t_stall = stall;
    exp_maddr = bufa; exp_saddr = longint'(lba) * BLKW;
    bib = 0; beats = 0; acc_s = 0; bad_m = 0; bad_s = 0;
    dir_to_disk = dir[0]; buf_addr = bufa; first_lba = lba[15:0]; blk_cnt = cnt[7:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 6000 && !seen; i++) begin
      if (poke && i == 5) begin
        dir_to_disk = ~dir[0]; first_lba = 16'd1; blk_cnt = 8'd5; start = 1'b1;
      end else begin
        start = 1'b0; dir_to_disk = dir[0]; first_lba = lba[15:0]; blk_cnt = cnt[7:0];
      end
      if (done) begin seen = 1'b1; got_out = int'(outcome); end
      else @(negedge clk);
    end
    start = 1'b0;
    check(seen, "R6", "done seen", seen, 1);
    @(negedge clk);
    check(!done && !busy, "R6", "done one cycle then idle", {done, busy}, 0);
  endtask

  int bad, lo, hi;

  initial begin
    pend_v = 1'b0; cyc = 0; overlap = 0; t_stall = 0; t_err_beat = 0;
    for (int i = 0; i < 4096; i++) mem[i] = 32'hA5000000 ^ i;
    for (int i = 0; i < 2048; i++) store[i] = (i * 32'h9E3779B9) ^ 32'h0F0F;
    repeat (3) @(negedge clk);
    check(!busy && !done && !m_req && !s_en, "R1", "reset outputs",
          {busy, done, m_req, s_en}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !done && !m_req && !s_en, "R1", "idle after reset",
          {busy, done, m_req, s_en}, 0);

    // R2: storage to memory, one block, no stalls
    lo = mem[63]; hi = mem[64 + BLKW];
    run(0, 32'h100, 3, 1, 0, 0, 0);
    check(got_out == 0, "R6", "read ok code", got_out, 0);
    bad = 0;
    for (int k = 0; k < BLKW; k++) if (mem[64 + k] != store[3*BLKW + k]) bad++;
    check(bad == 0, "R2", "memory copy", bad, 0);
    check(mem[63] == lo && mem[64 + BLKW] == hi, "R2", "memory guard", 0, 0);
    check(bad_m == 0, "R4", "burst addr/last/wr", bad_m, 0);
    check(bad_s == 0 && acc_s == BLKW && beats == BLKW, "R5", "storage addr/count",
          acc_s, BLKW);

    // R3: memory to storage, two blocks, stalls every 3rd cycle
    lo = store[10*BLKW - 1]; hi = store[12*BLKW];
    run(1, 32'h800, 10, 2, 0, 3, 0);
    check(got_out == 1, "R6", "write ok code", got_out, 1);
    bad = 0;
    for (int k = 0; k < 2*BLKW; k++) if (store[10*BLKW + k] != mem[512 + k]) bad++;
    check(bad == 0, "R3", "storage copy", bad, 0);
    check(store[10*BLKW - 1] == lo && store[12*BLKW] == hi, "R3", "storage guard", 0, 0);
    check(bad_m == 0, "R4", "stalled bursts", bad_m, 0);
    check(bad_s == 0 && acc_s == 2*BLKW, "R5", "storage sequence", acc_s, 2*BLKW);

    // R7: range ending exactly at the device end is accepted
    run(0, 32'h1000, 62, 2, 0, 2, 0);
    check(got_out == 0 && acc_s == 2*BLKW, "R7", "edge range ok", got_out, 0);
    bad = 0;
    for (int k = 0; k < 2*BLKW; k++) if (mem[1024 + k] != store[62*BLKW + k]) bad++;
    check(bad == 0 && bad_m == 0, "R7", "edge range data", bad, 0);

    // R7: one block past the end
    run(0, 32'h100, 63, 2, 0, 0, 0);
    check(got_out == 2 && acc_s == 0 && beats == 0, "R7", "read range error",
          got_out, 2);
    run(1, 32'h100, 64, 1, 0, 0, 0);
    check(got_out == 3 && acc_s == 0 && beats == 0, "R7", "write range error",
          got_out, 3);

    // R8: misaligned buffer
    run(0, 32'h102, 1, 1, 0, 0, 0);
    check(got_out == 2 && acc_s == 0 && beats == 0, "R8", "read misaligned", got_out, 2);
    run(1, 32'h101, 1, 1, 0, 0, 0);
    check(got_out == 3 && acc_s == 0 && beats == 0, "R8", "write misaligned", got_out, 3);

    // R10: zero blocks
    run(1, 32'h200, 5, 0, 0, 0, 0);
    check(got_out == 1 && acc_s == 0 && beats == 0, "R10", "zero count write", got_out, 1);
    run(0, 32'h200, 5, 0, 0, 0, 0);
    check(got_out == 0 && acc_s == 0 && beats == 0, "R10", "zero count read", got_out, 0);

    // R9: bus error mid-transfer
    run(0, 32'h400, 7, 2, 6, 0, 0);
    check(got_out == 2, "R9", "read abort code", got_out, 2);
    check(beats == 6 && acc_s == 8, "R9", "read traffic stops", {beats, acc_s}, {6, 8});
    run(1, 32'h400, 7, 2, 3, 2, 0);
    check(got_out == 3, "R9", "write abort code", got_out, 3);
    check(beats == 3 && acc_s == 0, "R9", "write traffic stops", {beats, acc_s}, {3, 0});

    // R11: start while busy is ignored
    run(0, 32'h1800, 20, 1, 0, 0, 1);
    check(got_out == 0 && acc_s == BLKW && bad_s == 0 && bad_m == 0, "R11",
          "run unchanged by extra start", got_out, 0);
    bad = 0;
    for (int k = 0; k < BLKW; k++) if (mem[1536 + k] != store[20*BLKW + k]) bad++;
    check(bad == 0, "R11", "data unchanged", bad, 0);
    acc_s = 0; beats = 0;
    repeat (20) @(negedge clk);
    check(!busy && acc_s == 0 && beats == 0, "R11", "no second run", acc_s, 0);

    check(overlap == 0, "R12", "sides never overlap", overlap, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL R6 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule